// File: doc/BRIEF.md
# Configurable Registered Digital Comparator

This block holds three independent 8-bit unsigned magnitude comparators. Each cell takes its positive and its negative operand from its own pair of 4:1 selectors. The sources are an ADC byte, either half of a 16-bit serial-interface word, two state-machine bytes, a counter byte and a per-cell constant. Each cell compares the two operands and produces three results: a strict greater-than flag, a main output that a mode bit can widen to greater-or-equal, and an equality flag.

All results are held in registers clocked by an oscillator clock. A shared 2-bit field chooses whether the results update on the rising or the falling edge of that clock. Each cell has its own power enable, which clears its results to zero while the enable is low. The data sources and the oscillator sit outside the block, and each arrives as a plain input port.

Top module: `dcmp_triple`

## Requirements
- R1: `out_gt[c]` becomes 1 when cell c's positive operand is greater than its negative operand, compared as unsigned 8-bit values, and 0 otherwise.
- R2: `out_eq[c]` becomes 1 exactly when the two operands of cell c are equal. It is never 1 at the same time as `out_gt[c]`.
- R3: With `ge_mode[c]`=0, `out_main[c]` equals the greater-than result. With `ge_mode[c]`=1, `out_main[c]` is 1 when the positive operand is greater than or equal to the negative one.
- R4: `pos_sel[2c+1:2c]` picks cell c's positive operand: 0 = `adc_byte`, 1 = a serial-word byte (see R6), 2 = `fsm0_byte`, 3 = `user_pos[8c+7:8c]`.
- R5: `neg_sel[2c+1:2c]` picks cell c's negative operand: 0 = a serial-word byte (see R6), 1 = `fsm0_byte`, 2 = `fsm1_byte` for cells 0 and 1 and `cnt_byte` for cell 2, 3 = `user_neg[8c+7:8c]`.
- R6: Cells 0 and 2 take `ser_word[15:8]` as their positive serial byte and `ser_word[7:0]` as their negative serial byte. Cell 1 takes them the other way round.
- R7: With `edge_sel`=01, the results update only on falling edges of `clk_osc`. With 00, 10 or 11, they update only on rising edges. Between those edges the results hold their value.
- R8: While `pwr_en[c]` is 0, all three results of cell c are loaded with 0 at each selected edge and stay 0, whatever the operands are.
- R9: While `rst_n` is low, all results are 0. Reset acts at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| edge_sel | input | 2 | Capture edge: 01 falling, others rising |
| pwr_en | input | 3 | Per-cell power enable |
| ge_mode | input | 3 | Per-cell greater-or-equal mode for out_main |
| pos_sel | input | 6 | Positive operand select, 2 bits per cell |
| neg_sel | input | 6 | Negative operand select, 2 bits per cell |
| adc_byte | input | 8 | ADC parallel byte |
| ser_word | input | 16 | Serial-interface word |
| fsm0_byte | input | 8 | State machine 0 byte |
| fsm1_byte | input | 8 | State machine 1 byte |
| cnt_byte | input | 8 | Counter byte (cell 2 only) |
| user_pos | input | 24 | Positive constants, 8 bits per cell |
| user_neg | input | 24 | Negative constants, 8 bits per cell |
| out_gt | output | 3 | Registered greater-than per cell |
| out_main | output | 3 | Registered main output per cell |
| out_eq | output | 3 | Registered equality per cell |

## Verification
Every result is due at the first selected clock edge after an input change. There is exactly one register between the inputs and the outputs, so the latency is a single edge. The one exception is reset, which clears the outputs at once with no edge. The bench changes inputs one nanosecond after a rising edge. Its reference model updates one bank of expected results on rising edges and another bank on falling edges. Half a nanosecond after every edge, the bench compares the outputs with the bank that the current edge selection names. A falling-edge result therefore cannot be credited at a rising edge, and a rising-edge result cannot be credited at a falling edge. The bench pulls reset low between edges and checks the outputs before the next edge arrives.

// File: rtl/dcmp_triple.sv
module dcmp_triple #(
  parameter int W = 8
) (
  input  logic           clk_osc,
  input  logic           rst_n,
  input  logic [1:0]     edge_sel,
  input  logic [2:0]     pwr_en,
  input  logic [2:0]     ge_mode,
  input  logic [5:0]     pos_sel,
  input  logic [5:0]     neg_sel,
  input  logic [W-1:0]   adc_byte,
  input  logic [2*W-1:0] ser_word,
  input  logic [W-1:0]   fsm0_byte,
  input  logic [W-1:0]   fsm1_byte,
  input  logic [W-1:0]   cnt_byte,
  input  logic [3*W-1:0] user_pos,
  input  logic [3*W-1:0] user_neg,
  output logic [2:0]     out_gt,
  output logic [2:0]     out_main,
  output logic [2:0]     out_eq
);
  localparam int N = 3;

  wire [W-1:0] ser_hi   = ser_word[2*W-1:W];
  wire [W-1:0] ser_lo   = ser_word[W-1:0];
  wire         use_fall = (edge_sel == 2'b01);

  for (genvar g = 0; g < N; g++) begin : g_cell
    wire [W-1:0] pos_lane = (g == 1) ? ser_lo : ser_hi;
    wire [W-1:0] neg_lane = (g == 1) ? ser_hi : ser_lo;
    wire [W-1:0] third    = (g == 2) ? cnt_byte : fsm1_byte;
    logic [W-1:0] pos_op, neg_op;
    logic [2:0]   rise_q, fall_q;

    always_comb begin
      case (pos_sel[2*g +: 2])
        2'd0:    pos_op = adc_byte;
        2'd1:    pos_op = pos_lane;
        2'd2:    pos_op = fsm0_byte;
        default: pos_op = user_pos[W*g +: W];
      endcase
      case (neg_sel[2*g +: 2])
        2'd0:    neg_op = neg_lane;
        2'd1:    neg_op = fsm0_byte;
        2'd2:    neg_op = third;
        default: neg_op = user_neg[W*g +: W];
      endcase
    end

    wire gt   = pos_op > neg_op;
    wire eq   = pos_op == neg_op;
    wire main = gt | (ge_mode[g] & eq);
    wire [2:0] nxt = pwr_en[g] ? {main, eq, gt} : 3'b000;

    always_ff @(posedge clk_osc or negedge rst_n)
      if (!rst_n) rise_q <= '0;
      else        rise_q <= nxt;

    always_ff @(negedge clk_osc or negedge rst_n)
      if (!rst_n) fall_q <= '0;
      else        fall_q <= nxt;

    wire [2:0] sel_q = use_fall ? fall_q : rise_q;
    assign out_gt[g]   = sel_q[0];
    assign out_eq[g]   = sel_q[1];
    assign out_main[g] = sel_q[2];
  end
endmodule

// File: rtl/dcmp_triple_chk.sv
module dcmp_triple_chk (
  input logic       clk_osc,
  input logic       rst_n,
  input logic [1:0] edge_sel,
  input logic [2:0] pwr_en,
  input logic [2:0] out_gt,
  input logic [2:0] out_main,
  input logic [2:0] out_eq
);
  assert_gt_eq_exclusive_R2: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (out_gt & out_eq) == 3'b000);

  assert_main_covers_gt_R3: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (out_gt & ~out_main) == 3'b000);

  assert_main_needs_gt_or_eq_R3: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (out_main & ~out_gt & ~out_eq) == 3'b000);

  assert_powered_down_zero_R8: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (edge_sel != 2'b01) |=> (edge_sel == 2'b01) ||
      (((out_gt | out_main | out_eq) & ~$past(pwr_en)) == 3'b000));

  always @(negedge clk_osc)
    if (!rst_n)
      assert_reset_clears_R9: assert ((out_gt | out_main | out_eq) == 3'b000);
endmodule

bind dcmp_triple dcmp_triple_chk u_chk (
  .clk_osc(clk_osc), .rst_n(rst_n), .edge_sel(edge_sel), .pwr_en(pwr_en),
  .out_gt(out_gt), .out_main(out_main), .out_eq(out_eq)
);

// File: tb/tb_dcmp_triple.sv
`timescale 1ns/100ps
module tb_dcmp_triple;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  edge_sel = 0;
  logic [2:0]  pwr_en = 0, ge_mode = 0;
  logic [5:0]  pos_sel = 0, neg_sel = 0;
  logic [7:0]  adc_byte = 0, fsm0_byte = 0, fsm1_byte = 0, cnt_byte = 0;
  logic [15:0] ser_word = 0;
  logic [23:0] user_pos = 0, user_neg = 0;
  logic [2:0]  out_gt, out_main, out_eq;

  int checks = 0, fails = 0;
  string tag = "R9";
  bit finished = 0;

  always #2 clk = ~clk;

  dcmp_triple dut (
    .clk_osc(clk), .rst_n(rst_n), .edge_sel(edge_sel), .pwr_en(pwr_en),
    .ge_mode(ge_mode), .pos_sel(pos_sel), .neg_sel(neg_sel),
    .adc_byte(adc_byte), .ser_word(ser_word), .fsm0_byte(fsm0_byte),
    .fsm1_byte(fsm1_byte), .cnt_byte(cnt_byte), .user_pos(user_pos),
    .user_neg(user_neg), .out_gt(out_gt), .out_main(out_main), .out_eq(out_eq)
  );

  // expected {main, eq, gt} of cell c from the requirements
  function automatic logic [2:0] expect_cell(int c);
    int p, n;
    case (pos_sel[2*c +: 2])
      0: p = adc_byte;
      1: p = (c == 1) ? ser_word[7:0] : ser_word[15:8];
      2: p = fsm0_byte;
      default: p = user_pos[8*c +: 8];
    endcase
    case (neg_sel[2*c +: 2])
      0: n = (c == 1) ? ser_word[15:8] : ser_word[7:0];
      1: n = fsm0_byte;
      2: n = (c == 2) ? cnt_byte : fsm1_byte;
      default: n = user_neg[8*c +: 8];
    endcase
    if (!pwr_en[c]) return 3'b000;
    return {(p > n) || (ge_mode[c] && p == n), p == n, p > n};
  endfunction

  logic [2:0] m_rise [3];
  logic [2:0] m_fall [3];

  always @(posedge clk or negedge rst_n)
    for (int c = 0; c < 3; c++) m_rise[c] <= !rst_n ? 3'b000 : expect_cell(c);
  always @(negedge clk or negedge rst_n)
    for (int c = 0; c < 3; c++) m_fall[c] <= !rst_n ? 3'b000 : expect_cell(c);

  task automatic check_bit(string what, int c, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cell%0d t=%0t actual=%b expected=%b", tag, what, c, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    for (int c = 0; c < 3; c++) begin
      logic [2:0] e;
      e = (edge_sel == 2'b01) ? m_fall[c] : m_rise[c];
      check_bit("out_gt",   c, out_gt[c],   e[0]);
      check_bit("out_eq",   c, out_eq[c],   e[1]);
      check_bit("out_main", c, out_main[c], e[2]);
    end
  endtask

  always @(posedge clk or negedge clk) begin
    #0.5;
    if (!finished) compare_all();
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tag = "R9";
    step(3);
    rst_n = 1;
    pwr_en = 3'b111;
    adc_byte = 8'h80; ser_word = 16'h4020; fsm0_byte = 8'h10;
    fsm1_byte = 8'h90; cnt_byte = 8'h05;
    user_pos = {3{8'h30}}; user_neg = {3{8'h30}};
    step(2);

    tag = "R4 R6";
    neg_sel = 6'b111111;
    for (int s = 0; s < 4; s++) begin
      pos_sel = {3{s[1:0]}};
      step(2);
    end

    tag = "R5 R6";
    pos_sel = 6'b111111;
    for (int s = 0; s < 4; s++) begin
      neg_sel = {3{s[1:0]}};
      step(2);
    end

    tag = "R3";
    neg_sel = 6'b111111;
    ge_mode = 3'b101; step(2);
    ge_mode = 3'b010; step(2);
    user_pos = {8'h31, 8'h2f, 8'h30}; step(2);

    tag = "R7";
    for (int e = 0; e < 4; e++) begin
      edge_sel = e[1:0];
      for (int k = 0; k < 4; k++) begin
        user_pos = {8'h30 + 8'(k), 8'h31 - 8'(k), 8'h2f + 8'(k)};
        step(1);
      end
    end
    edge_sel = 2'b00;

    tag = "R8";
    user_pos = {3{8'hff}}; user_neg = {3{8'h00}}; ge_mode = 3'b111;
    step(2);
    pwr_en = 3'b101; step(3);
    edge_sel = 2'b01; pwr_en = 3'b010; step(3);
    pwr_en = 3'b111; edge_sel = 2'b00; step(2);

    tag = "R1 R2 R3";
    for (int i = 0; i < 300; i++) begin
      adc_byte = 8'($urandom); ser_word = 16'($urandom);
      fsm0_byte = 8'($urandom); fsm1_byte = 8'($urandom); cnt_byte = 8'($urandom);
      user_pos = 24'($urandom); user_neg = 24'($urandom);
      pos_sel = 6'($urandom); neg_sel = 6'($urandom); ge_mode = 3'($urandom);
      if (i % 8 == 0) user_neg = user_pos;
      if (i % 37 == 0) edge_sel = 2'($urandom);
      step(1);
    end

    tag = "R9";
    edge_sel = 2'b00; pos_sel = 6'b111111; neg_sel = 6'b111111;
    user_pos = {3{8'h90}}; user_neg = {3{8'h10}};
    step(2);
    rst_n = 0;
    #0.5;
    for (int c = 0; c < 3; c++) begin
      check_bit("out_gt async",   c, out_gt[c],   1'b0);
      check_bit("out_main async", c, out_main[c], 1'b0);
      check_bit("out_eq async",   c, out_eq[c],   1'b0);
    end
    step(2);
    rst_n = 1;
    step(2);
    finish_run();
  end
endmodule